// File: doc/BRIEF.md
# Chained Indirect Address Resolver

This block works out the effective address of a memory-reference instruction for a processor with a 16-bit word. The instruction word carries an indirect flag in its top bit and an address in the other fifteen bits. When the flag is clear, the indexed address is the result. When the flag is set, the block reads the word at that address over a synchronous memory port. It keeps following pointer words for as long as each fetched word has its flag set. A mode input limits this to a single level, and in that case the flag of the fetched word is ignored.

Two fixed windows of eight cells in low memory act as stepping pointers. A pointer read from word 8 to 15 is written back one higher, and a pointer read from word 16 to 23 is written back one lower. The old value is used for the address in both cases. An optional offset is added to every address field before it is used, so indexing comes ahead of indirection at each level. A depth limit ends a circular chain with an error.

FSM states: `ST_IDLE` (waits for `start`), `ST_FETCH` (drives the read), `ST_EVAL` (looks at the returned word and drives any write-back). Transitions: IDLE to IDLE on a direct start, which gives done at once. IDLE to FETCH on an indirect start. FETCH to EVAL always. EVAL to FETCH when the chain continues. EVAL to IDLE when the chain ends or hits the depth limit.

Top module: `ptr_chain_resolver`

## Requirements
- R1: After reset, `done`, `chain_err`, `busy`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: An idle start with `instr_word[15]` = 0 raises `done` on the next clock. `eff_addr` = (`instr_word[14:0]` + `index_off`) mod 2^15, and there is no memory access.
- R3: An idle start with `instr_word[15]` = 1 reads the word at (`instr_word[14:0]` + `index_off`) mod 2^15. If that word has bit 15 clear, `eff_addr` = (its bits 14..0 + `index_off`) mod 2^15.
- R4: With `chain_mode` = 1, every fetched word with bit 15 set causes a further read at (its bits 14..0 + `index_off`) mod 2^15. Each read costs two cycles, so `done` comes 2·N+1 clocks after the accepting edge for N reads.
- R5: With `chain_mode` = 0, exactly one read is made. Bit 15 of the fetched word is ignored and its indexed bits 14..0 are the result.
- R6: A read from word address 8 to 15 writes back (word + 1) mod 2^16 to the same cell. The result uses the value from before the update.
- R7: A read from word address 16 to 23 writes back (word − 1) mod 2^16 to the same cell. The result uses the value from before the update.
- R8: A write-back is issued in the cycle after its read, on its own, and always before the next read.
- R9: If MAX_DEPTH reads (default 64) all return bit 15 set in chain mode, `done` rises together with `chain_err` = 1 and `eff_addr` = 0. No more than MAX_DEPTH reads are made.
- R10: `start` is ignored while `busy` is high.
- R11: `done` lasts a single cycle. `busy` is high from the clock after an indirect start until the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a resolution (taken only when idle) |
| instr_word | input | 16 | Bit 15 indirect flag, bits 14..0 address |
| index_off | input | 15 | Offset added to every address field |
| chain_mode | input | 1 | 1: unlimited chaining, 0: single level |
| mem_rd_en | output | 1 | Read strobe, data returned next cycle |
| mem_wr_en | output | 1 | Write strobe for pointer update |
| mem_addr | output | 15 | Word address for read or write |
| mem_wdata | output | 16 | Updated pointer value |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd_en` |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 15 | Effective address, valid with `done` |
| chain_err | output | 1 | Depth limit reached, valid with `done` |

## Verification
The hardest case to reach is the depth abort. It needs a pointer chain that never ends, so the bench stores a cell that points to itself and lets the resolver go round it until the limit. A second hard case is a chain that passes through a stepping cell partway along. To reach it, the bench builds a chain that enters the auto-increment window on its second level. The bench memory then shows whether the write-back landed between two reads, and the following run shows whether the updated pointer is the one followed.

// File: rtl/ptrres_pkg.sv
package ptrres_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EVAL  = 2'd2
    } res_state_t;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_INC  = 2'd1,
        WIN_DEC  = 2'd2
    } win_kind_t;
endpackage

// File: rtl/ptrres_index_add.sv
module ptrres_index_add #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] sum
);
    always_comb sum = base + offset;
endmodule

// File: rtl/ptrres_window.sv
module ptrres_window
    import ptrres_pkg::*;
#(
    parameter int AW        = 15,
    parameter int INC_BASE  = 8,
    parameter int DEC_BASE  = 16,
    parameter int WIN_CELLS = 8
) (
    input  logic [AW-1:0] addr,
    output win_kind_t     kind
);
    localparam logic [AW-1:0] INC_LO = AW'(INC_BASE);
    localparam logic [AW-1:0] INC_HI = AW'(INC_BASE + WIN_CELLS - 1);
    localparam logic [AW-1:0] DEC_LO = AW'(DEC_BASE);
    localparam logic [AW-1:0] DEC_HI = AW'(DEC_BASE + WIN_CELLS - 1);

    always_comb begin
        if (addr >= INC_LO && addr <= INC_HI)
            kind = WIN_INC;
        else if (addr >= DEC_LO && addr <= DEC_HI)
            kind = WIN_DEC;
        else
            kind = WIN_NONE;
    end
endmodule

// File: rtl/ptrres_depth_ctr.sv
module ptrres_depth_ctr #(
    parameter int MAX_DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last_read
);
    localparam int CW = $clog2(MAX_DEPTH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_DEPTH - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + CW'(1);
    end

    always_comb last_read = (cnt_q == LIMIT);
endmodule

// File: rtl/ptr_chain_resolver.sv
module ptr_chain_resolver
    import ptrres_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 64,
    parameter int INC_BASE  = 8,
    parameter int DEC_BASE  = 16,
    parameter int WIN_CELLS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   instr_word,
    input  logic [DATA_W-2:0]   index_off,
    input  logic                chain_mode,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [DATA_W-2:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-2:0]   eff_addr,
    output logic                chain_err
);
    localparam int AW   = DATA_W - 1;
    localparam int FLAG = DATA_W - 1;

    res_state_t      state_q, state_d;
    logic [AW-1:0]   ptr_q, off_q, eff_q;
    logic            multi_q, done_q, err_q;

    logic [AW-1:0]   first_addr, next_addr;
    win_kind_t       win;
    logic            last_read, follow;

    ptrres_index_add #(.AW(AW)) u_add_first (
        .base(instr_word[AW-1:0]), .offset(index_off), .sum(first_addr)
    );

    ptrres_index_add #(.AW(AW)) u_add_next (
        .base(mem_rdata[AW-1:0]), .offset(off_q), .sum(next_addr)
    );

    ptrres_window #(
        .AW(AW), .INC_BASE(INC_BASE), .DEC_BASE(DEC_BASE), .WIN_CELLS(WIN_CELLS)
    ) u_win (
        .addr(ptr_q), .kind(win)
    );

    ptrres_depth_ctr #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_IDLE),
        .step(state_q == ST_EVAL),
        .last_read(last_read)
    );

    always_comb follow = multi_q && mem_rdata[FLAG];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && instr_word[FLAG]) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_EVAL;
            ST_EVAL:  state_d = (follow && !last_read) ? ST_FETCH : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            off_q   <= '0;
            eff_q   <= '0;
            multi_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (instr_word[FLAG]) begin
                            ptr_q   <= first_addr;
                            off_q   <= index_off;
                            multi_q <= chain_mode;
                        end else begin
                            eff_q  <= first_addr;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_FETCH: ;
                ST_EVAL: begin
                    if (follow) begin
                        if (last_read) begin
                            eff_q  <= '0;
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            ptr_q <= next_addr;
                        end
                    end else begin
                        eff_q  <= next_addr;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // memory port
    always_comb begin
        mem_addr  = ptr_q;
        mem_rd_en = (state_q == ST_FETCH);
        mem_wr_en = (state_q == ST_EVAL) && (win != WIN_NONE);
        mem_wdata = (win == WIN_INC) ? mem_rdata + DATA_W'(1)
                                     : mem_rdata - DATA_W'(1);
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        chain_err = err_q;
        eff_addr  = eff_q;
    end
endmodule

// File: rtl/ptrres_checks.sv
module ptrres_checks #(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 64,
    parameter int INC_BASE  = 8,
    parameter int DEC_BASE  = 16,
    parameter int WIN_CELLS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] instr_word,
    input logic              busy,
    input logic              done,
    input logic              chain_err,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [DATA_W-2:0] mem_addr
);
    logic [31:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || (start && !busy))
            rd_cnt <= '0;
        else if (mem_rd_en)
            rd_cnt <= rd_cnt + 32'd1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));                          // R1

    AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !instr_word[DATA_W-1]) |=> (done && !chain_err && !busy)); // R2

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (int'(mem_addr) >= INC_BASE && int'(mem_addr) < INC_BASE + WIN_CELLS)
                   || (int'(mem_addr) >= DEC_BASE && int'(mem_addr) < DEC_BASE + WIN_CELLS)); // R6

    AST_WR_NOT_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !mem_rd_en);                                      // R8

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && $stable(mem_addr)));          // R8

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= MAX_DEPTH);                                           // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> done);                                            // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                                // R11
endmodule

bind ptr_chain_resolver ptrres_checks #(
    .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .INC_BASE(INC_BASE),
    .DEC_BASE(DEC_BASE), .WIN_CELLS(WIN_CELLS)
) u_checks (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
    .busy(busy), .done(done), .chain_err(chain_err),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr)
);

// File: tb/tb_ptr_chain_resolver.sv
`timescale 1ns/1ps
module tb_ptr_chain_resolver;
    localparam int MAXD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_word = '0;
    logic [14:0] index_off = '0;
    logic        chain_mode = 1'b1;
    logic        mem_rd_en, mem_wr_en, busy, done, chain_err;
    logic [14:0] mem_addr, eff_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem    [0:32767];
    logic [15:0] refmem [0:32767];

    int vectors = 0;
    int errors  = 0;
    int rd_total = 0;
    int overlap  = 0;

    always #5 clk = ~clk;

    ptr_chain_resolver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .index_off(index_off), .chain_mode(chain_mode),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .eff_addr(eff_addr), .chain_err(chain_err)
    );

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_total  <= rd_total + 1;
        end
        if (mem_rd_en && mem_wr_en) overlap <= overlap + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] v);
        mem[a]    = v;
        refmem[a] = v;
    endtask

    // behavioural reference: returns effective address, error flag, read count
    task automatic model(input logic [15:0] iw, input logic [14:0] off, input bit multi,
                         output logic [14:0] e, output bit err, output int reads);
        logic [14:0] a;
        logic [15:0] w;
        bit going;
        reads = 0; err = 0;
        a = iw[14:0] + off;
        e = a;
        going = iw[15];
        while (going) begin
            w = refmem[a];
            reads++;
            if (a >= 8 && a <= 15)       refmem[a] = w + 16'd1;
            else if (a >= 16 && a <= 23) refmem[a] = w - 16'd1;
            if (multi && w[15]) begin
                if (reads == MAXD) begin
                    err = 1; e = '0; going = 0;
                end else a = w[14:0] + off;
            end else begin
                e = w[14:0] + off;
                going = 0;
            end
        end
    endtask

    task automatic run_op(input logic [15:0] iw, input logic [14:0] off, input bit multi,
                          input bit glitch, input string req);
        logic [14:0] e;
        bit err;
        int reads, lat, rd0;
        model(iw, off, multi, e, err, reads);
        lat = iw[15] ? 2 * reads + 1 : 1;
        rd0 = rd_total;
        @(negedge clk);
        start = 1'b1; instr_word = iw; index_off = off; chain_mode = multi;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            if (c > 1) @(negedge clk);
            check({req, " done"}, int'(done), int'(c == lat));
            check("R11 busy", int'(busy), int'(c < lat && iw[15]));
            if (glitch && c == 2) begin
                start = 1'b1; instr_word = 16'h0ABC; index_off = 15'd3;   // R10 stimulus
            end
            if (glitch && c == 3) begin
                start = 1'b0; instr_word = iw; index_off = off;
            end
            if (c == lat) begin
                check({req, " eff_addr"}, int'(eff_addr), int'(e));
                check({req, " chain_err"}, int'(chain_err), int'(err));
            end
        end
        @(negedge clk);
        check("R11 done one cycle", int'(done), 0);
        check({req, " read count"}, rd_total - rd0, reads);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32768; i++) begin
            mem[i] = '0; refmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1 done", int'(done), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 chain_err", int'(chain_err), 0);
        check("R1 rd/wr", int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;

        // R2 direct, with and without offset wrap
        run_op(16'h0123, 15'd0, 1'b1, 1'b0, "R2");
        run_op(16'h7FFF, 15'd2, 1'b1, 1'b0, "R2 wrap");

        // R3 one level
        poke(200, 16'h0500);
        run_op(16'h80C8, 15'd0, 1'b1, 1'b0, "R3");

        // R4 three-level chain, with a start pulse while busy (R10)
        poke(300, 16'h812D);
        poke(301, 16'h8190);
        poke(400, 16'h0777);
        run_op(16'h812C, 15'd0, 1'b1, 1'b1, "R4 R10");

        // R5 single level stops at first fetched word
        run_op(16'h812C, 15'd0, 1'b0, 1'b0, "R5");

        // R4 offset applied at every level
        poke(500, 16'h8257);
        poke(600, 16'h0010);
        run_op(16'h81F3, 15'd1, 1'b1, 1'b0, "R4 offset");

        // R6 auto-increment cell, old value used
        poke(10, 16'h0040);
        run_op(16'h800A, 15'd0, 1'b1, 1'b0, "R6");
        check("R6 cell after", int'(mem[10]), 16'h0041);
        run_op(16'h800A, 15'd0, 1'b1, 1'b0, "R6 second");
        check("R6 cell after second", int'(mem[10]), 16'h0042);

        // R7 auto-decrement cell with wrap, then follow the wrapped word
        poke(20, 16'h0000);
        run_op(16'h8014, 15'd0, 1'b1, 1'b0, "R7");
        check("R7 cell after", int'(mem[20]), 16'hFFFF);
        run_op(16'h8014, 15'd0, 1'b1, 1'b0, "R7 chained");
        check("R7 cell after second", int'(mem[20]), 16'hFFFE);

        // R8 stepping cell inside a chain
        poke(700, 16'h800B);
        poke(11, 16'h8320);
        poke(800, 16'h0042);
        run_op(16'h82BC, 15'd0, 1'b1, 1'b0, "R8");
        check("R8 cell 11", int'(mem[11]), int'(refmem[11]));
        poke(801, 16'h0043);
        run_op(16'h82BC, 15'd0, 1'b1, 1'b0, "R8 updated pointer");
        check("R8 no read/write overlap", overlap, 0);

        // R9 self-referencing pointer
        poke(900, 16'h8384);
        run_op(16'h8384, 15'd0, 1'b1, 1'b0, "R9");

        // recover with a direct op after the abort
        run_op(16'h0055, 15'd5, 1'b0, 1'b0, "R2 after abort");

        for (int a = 8; a < 24; a++)
            check("R6 R7 window cells", int'(mem[a]), int'(refmem[a]));

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule